// File: doc/BRIEF.md
# Multi-Mode CORDIC Master with Direction Broadcast

This block is an iterative shift-and-add CORDIC engine working on signed two's-complement x, y and angle words. It runs in one of three modes: circular vectoring, which turns the input vector onto the positive x axis and adds its angle to the angle word; circular rotation, which turns the vector by the angle word; and hyperbolic vectoring, which drives y to zero along a hyperbola and adds the inverse hyperbolic tangent of y/x to the angle word. The only difference between the circular and hyperbolic x update is one XOR of the direction bit with a hyperbolic flag, and that XOR sets the add/subtract sign.

Each micro-iteration takes one clock. During it the block presents the chosen rotation direction on a one-bit output with a valid strobe. Follower rotators that know the shift schedule can repeat the same rotation on their own data from that bit stream alone, with no angle word. The block applies no gain correction, so the magnitudes it returns are scaled by the CORDIC gain of the mode.

Top module: `cordic_master`

## Requirements
- R1: While reset is asserted, and after it, before any operation, `done` and `dir_valid` are 0 and `x_out`, `y_out`, `z_out` are 0.
- R2: Mode code 2'b00 (circular vectoring), for x_in > 0: `z_out` is z_in + atan2(y_in, x_in) in angle codes, where pi maps to 2^(W-1)-1. `x_out` is Kc·sqrt(x_in²+y_in²), with Kc the product of sqrt(1+2^-2s) over the shifts applied. `y_out` is close to 0.
- R3: Mode code 2'b01 (circular rotation): (`x_out`, `y_out`) is Kc times the input vector turned counter-clockwise by z_in, and `z_out` is close to 0.
- R4: Mode code 2'b10 (hyperbolic vectoring), for x_in > |y_in|/0.8: `z_out` is z_in + atanh(y_in/x_in) in angle codes. `x_out` is Kh·sqrt(x_in²−y_in²), with Kh the product of sqrt(1−2^-2s) over the shifts applied. `y_out` is close to 0.
- R5: `dir_valid` is high for exactly ITERS consecutive cycles per operation, once per micro-iteration. A follower that starts from (x_in, y_in) and, at each valid bit, applies the same step (dir=1 gives x −= σ·(y>>>s), y += x>>>s; dir=0 gives the opposite signs, with σ=+1 in circular and −1 in hyperbolic mode) reproduces `x_out` and `y_out` bit for bit.
- R6: In the circular modes the shift at step k is k. In hyperbolic mode the shifts start at 1 and rise by one per step, except that shift 4 (and 13, 40, …) is applied twice: 1,2,3,4,4,5,6,…
- R7: In both vectoring modes `dir` is 1 exactly when the current y is negative. In rotation mode `dir` is 1 exactly when the residual angle is non-negative.
- R8: `done` is a one-cycle pulse in the cycle after the last micro-iteration, ITERS+1 cycles after the clock edge that accepted `start`. The outputs then hold until the next accepted start.
- R9: `start` is ignored while an operation is in progress: inputs presented then do not change its result or its length.
- R10: `start` with the reserved mode code 2'b11 is ignored: no `dir_valid`, no `done`, outputs unchanged.
- R11: All shifts are arithmetic, so small negative values settle at −1 rather than 0. The follower of R5 matches exactly on small-magnitude negative vectors too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | 00 circular vectoring, 01 circular rotation, 10 hyperbolic vectoring, 11 reserved |
| x_in | input | W | Signed x operand |
| y_in | input | W | Signed y operand |
| z_in | input | W | Signed angle operand (pi = 2^(W-1)-1) |
| dir_valid | output | 1 | High during each micro-iteration |
| dir | output | 1 | Rotation direction of the current micro-iteration |
| x_out | output | W | Final x |
| y_out | output | W | Final y |
| z_out | output | W | Final angle word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with W = 15 and ITERS = 10. With these values the hyperbolic schedule reaches its first repeated shift (4) but not the second. The last shift, 9, sets an angle resolution of roughly ten codes, which the tolerances on the real-valued results reflect. A bit-exact follower model driven only by the broadcast directions checks the broadcast itself. On tiny negative operands, at this width, the arithmetic shifts settle at −1, which the follower must reproduce.

// File: rtl/cordic_master_pkg.sv
package cordic_master_pkg;

  localparam int STEP_IDX_W = 6;
  localparam real PI_R = 3.14159265358979323846;

  typedef enum logic [1:0] {
    MODE_CVEC = 2'b00,
    MODE_CROT = 2'b01,
    MODE_HVEC = 2'b10,
    MODE_RSVD = 2'b11
  } cmode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic                  load;
    logic                  step;
    logic                  hyp;
    logic                  vec;
    logic [STEP_IDX_W-1:0] shift;
  } strobe_t;

  // radians to angle code, pi -> 2^(w-1)-1, round to nearest (non-negative input)
  function automatic int angle_code(input real rad, input int w);
    return $rtoi(rad * ((2.0 ** (w - 1)) - 1.0) / PI_R + 0.5);
  endfunction

endpackage

// File: rtl/cordic_master_ctrl.sv
module cordic_master_ctrl
  import cordic_master_pkg::*;
#(
  parameter int ITERS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  output strobe_t    ctl,
  output logic       dirValid,
  output logic       done
);

  localparam int CW = $clog2(ITERS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e                st;
  logic [CW-1:0]         cnt;
  logic [STEP_IDX_W-1:0] shift;
  logic [STEP_IDX_W-1:0] nextRep;
  logic                  repDone;
  logic                  hypR;
  logic                  vecR;
  logic                  accept;
  logic                  atRepeat;

  assign accept   = (st == S_IDLE) && start && (mode != MODE_RSVD);
  assign atRepeat = hypR && (shift == nextRep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      shift   <= '0;
      nextRep <= '0;
      repDone <= 1'b0;
      hypR    <= 1'b0;
      vecR    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            st      <= S_RUN;
            cnt     <= '0;
            hypR    <= (mode == MODE_HVEC);
            vecR    <= (mode != MODE_CROT);
            shift   <= (mode == MODE_HVEC) ? STEP_IDX_W'(1) : '0;
            nextRep <= STEP_IDX_W'(4);
            repDone <= 1'b0;
          end
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ITERS - 1)) st <= S_FIN;
          if (atRepeat && !repDone) begin
            repDone <= 1'b1;
          end else begin
            shift <= shift + 1'b1;
            if (atRepeat) begin
              nextRep <= STEP_IDX_W'(nextRep * 3 + 1);
              repDone <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load  = accept;
    ctl.step  = (st == S_RUN);
    ctl.hyp   = hypR;
    ctl.vec   = vecR;
    ctl.shift = shift;
  end

  assign dirValid = (st == S_RUN);
  assign done     = (st == S_FIN);

  // R8: completion strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion directly follows a micro-iteration
  a_r8_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dirValid));

  // R10: reserved mode code never leaves idle
  a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && mode == MODE_RSVD) |=> (st == S_IDLE));

  // R6: hyperbolic steps never use shift 0
  a_r6_hyp_shift_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && ctl.hyp) |-> (ctl.shift != '0));

  // R9: a start while busy does not alter the captured mode
  a_r9_busy_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && start) |=> (hypR == $past(hypR) && vecR == $past(vecR)));

endmodule

// File: rtl/cordic_master_dp.sv
module cordic_master_dp
  import cordic_master_pkg::*;
#(
  parameter int W     = 15,
  parameter int ITERS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             ctl,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  input  logic signed [W-1:0] zIn,
  output logic                dirNow,
  output logic signed [W-1:0] xQ,
  output logic signed [W-1:0] yQ,
  output logic signed [W-1:0] zQ
);

  localparam int TAB  = ITERS + 1;
  localparam int SIDX = $clog2(TAB);

  logic signed [W-1:0] circTab [TAB];
  logic signed [W-1:0] hypTab  [TAB];

  for (genvar i = 0; i < TAB; i++) begin : g_rom
    localparam int CIRC_C = angle_code($atan(2.0 ** (-i)), W);
    localparam int HYP_C  = angle_code($atanh((i == 0) ? 0.0 : 2.0 ** (-i)), W);
    assign circTab[i] = W'(CIRC_C);
    assign hypTab[i]  = W'(HYP_C);
  end

  logic [SIDX-1:0]     idx;
  logic signed [W-1:0] xSh, ySh, ang;
  logic signed [W-1:0] xNext, yNext, zNext;
  logic                xSub;

  always_comb begin
    idx    = ctl.shift[SIDX-1:0];
    ang    = ctl.hyp ? hypTab[idx] : circTab[idx];
    xSh    = xQ >>> ctl.shift;
    ySh    = yQ >>> ctl.shift;
    dirNow = ctl.vec ? yQ[W-1] : ~zQ[W-1];
    // coordinate-system sign via a single XOR
    xSub   = dirNow ^ ctl.hyp;
    xNext  = xSub   ? (xQ - ySh) : (xQ + ySh);
    yNext  = dirNow ? (yQ + xSh) : (yQ - xSh);
    zNext  = dirNow ? (zQ - ang) : (zQ + ang);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xQ <= '0;
      yQ <= '0;
      zQ <= '0;
    end else if (ctl.load) begin
      xQ <= xIn;
      yQ <= yIn;
      zQ <= zIn;
    end else if (ctl.step) begin
      xQ <= xNext;
      yQ <= yNext;
      zQ <= zNext;
    end
  end

  // R8: results hold whenever the sequencer is neither loading nor stepping
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.step) |=> ($stable(xQ) && $stable(yQ) && $stable(zQ)));

endmodule

// File: rtl/cordic_master.sv
module cordic_master
  import cordic_master_pkg::*;
#(
  parameter int W     = 15,
  parameter int ITERS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  output logic                dir_valid,
  output logic                dir,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out,
  output logic                done
);

  strobe_t ctl;

  cordic_master_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .ctl      (ctl),
    .dirValid (dir_valid),
    .done     (done)
  );

  cordic_master_dp #(.W(W), .ITERS(ITERS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .xIn    (x_in),
    .yIn    (y_in),
    .zIn    (z_in),
    .dirNow (dir),
    .xQ     (x_out),
    .yQ     (y_out),
    .zQ     (z_out)
  );

endmodule

// File: tb/cordic_master_tb.sv
`timescale 1ns/1ps
module cordic_master_tb;

  localparam int  W  = 15;
  localparam int  N  = 10;
  localparam int  NV = 8;
  localparam real PI = 3.14159265358979323846;

  localparam logic [1:0] TM [NV] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10};
  localparam int TX [NV] = '{6000, 5000, 7000, 6000, 4000, -3000, 6000, 7000};
  localparam int TY [NV] = '{3000, -5000, 0, 0, 3000, 2000, 2000, -3500};
  localparam int TZ [NV] = '{0, 0, 1000, 4096, -5461, 2731, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic signed [W-1:0] x_in = '0, y_in = '0, z_in = '0;
  logic dir_valid, dir, done;
  logic signed [W-1:0] x_out, y_out, z_out;

  always #2.5 clk = ~clk;

  cordic_master #(.W(W), .ITERS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .dir_valid(dir_valid), .dir(dir),
    .x_out(x_out), .y_out(y_out), .z_out(z_out), .done(done)
  );

  int nChk = 0, nBad = 0, cyc = 0;
  logic dirs [N+4];
  int nDir, lat;
  bit sawDone;
  real scale, kc, kh;

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_up();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // R6 shift schedule
  function automatic int shift_at(input bit hyp, input int k);
    int s, rep;
    bit rdone;
    if (!hyp) return k;
    s = 1; rep = 4; rdone = 0;
    for (int j = 0; j < k; j++) begin
      if (s == rep && !rdone) rdone = 1;
      else begin
        if (s == rep) begin rep = 3 * rep + 1; rdone = 0; end
        s++;
      end
    end
    return s;
  endfunction

  // issue one operation and collect the broadcast directions
  task automatic run_op(input logic [1:0] m, input int xi, input int yi, input int zi,
                        input bit poke);
    @(negedge clk);
    mode = m; x_in = W'(xi); y_in = W'(yi); z_in = W'(zi); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nDir = 0; lat = 0; sawDone = 0;
    for (int t = 0; t < 100; t++) begin
      lat++;
      if (dir_valid && nDir < N + 4) begin dirs[nDir] = dir; nDir++; end
      if (done) begin sawDone = 1; break; end
      if (poke && lat == 3) begin
        start = 1'b1; mode = 2'b01; x_in = W'(-1234); y_in = W'(4321); z_in = W'(-3000);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // R5/R11 follower driven only by the direction bits
  task automatic follow_check(input logic [1:0] m, input int xi, input int yi, input string req);
    logic signed [W-1:0] fx, fy, xs, ys;
    bit hyp;
    int s;
    hyp = (m == 2'b10);
    fx = W'(xi); fy = W'(yi);
    for (int k = 0; k < nDir && k < N; k++) begin
      s  = shift_at(hyp, k);
      xs = fx >>> s;
      ys = fy >>> s;
      if (dirs[k] ^ hyp) fx = fx - ys; else fx = fx + ys;
      if (dirs[k]) fy = fy + xs; else fy = fy - xs;
    end
    check(fx == x_out, req, "follower x", x_out, fx);
    check(fy == y_out, req, "follower y", y_out, fy);
  endtask

  task automatic verify(input logic [1:0] m, input int xi, input int yi, input int zi);
    real xr, yr, th, ez, ex, ey;
    xr = $itor(xi); yr = $itor(yi);
    check(sawDone, "R8", "done seen", sawDone, 1);
    check(lat == N + 1, "R8", "latency to done", lat, N + 1);
    check(nDir == N, "R5", "direction strobes", nDir, N);
    if (m == 2'b01) begin
      th = $itor(zi) / scale;
      ex = kc * (xr * $cos(th) - yr * $sin(th));
      ey = kc * (xr * $sin(th) + yr * $cos(th));
      ez = 0.0;
      check(dirs[0] == (zi >= 0), "R7", "first dir rotation", dirs[0], zi >= 0);
      check(absl(longint'(x_out) - longint'($rtoi(ex))) <= 48, "R3", "x", x_out, $rtoi(ex));
      check(absl(longint'(y_out) - longint'($rtoi(ey))) <= 48, "R3", "y", y_out, $rtoi(ey));
      check(absl(longint'(z_out)) <= 24, "R3", "residual angle", z_out, 0);
    end else if (m == 2'b00) begin
      ez = $itor(zi) + $atan2(yr, xr) * scale;
      ex = kc * $sqrt(xr * xr + yr * yr);
      check(dirs[0] == (yi < 0), "R7", "first dir vectoring", dirs[0], yi < 0);
      check(absl(longint'(z_out) - longint'($rtoi(ez))) <= 24, "R2", "angle", z_out, $rtoi(ez));
      check(absl(longint'(x_out) - longint'($rtoi(ex))) <= 48, "R2", "magnitude", x_out, $rtoi(ex));
      check(absl(longint'(y_out)) <= 48, "R2", "y nulled", y_out, 0);
    end else begin
      ez = $itor(zi) + $atanh(yr / xr) * scale;
      ex = kh * $sqrt(xr * xr - yr * yr);
      check(dirs[0] == (yi < 0), "R7", "first dir hyperbolic", dirs[0], yi < 0);
      check(absl(longint'(z_out) - longint'($rtoi(ez))) <= 30, "R4", "angle", z_out, $rtoi(ez));
      check(absl(longint'(x_out) - longint'($rtoi(ex))) <= 60, "R4", "magnitude", x_out, $rtoi(ex));
      check(absl(longint'(y_out)) <= 60, "R4", "y nulled", y_out, 0);
    end
    follow_check(m, xi, yi, (m == 2'b10) ? "R6" : "R5");
  endtask

  initial begin
    logic signed [W-1:0] hx, hy, hz;
    bit sawAny;
    scale = ((2.0 ** (W - 1)) - 1.0) / PI;
    kc = 1.0; kh = 1.0;
    for (int k = 0; k < N; k++) begin
      kc = kc * $sqrt(1.0 + 2.0 ** (-2 * shift_at(0, k)));
      kh = kh * $sqrt(1.0 - 2.0 ** (-2 * shift_at(1, k)));
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!done && !dir_valid, "R1", "strobes in reset", {done, dir_valid}, 0);
    check(x_out == 0 && y_out == 0 && z_out == 0, "R1", "outputs in reset", x_out | y_out | z_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !dir_valid && x_out == 0, "R1", "idle after reset", {done, dir_valid}, 0);

    // table-driven main function
    for (int v = 0; v < NV; v++) begin
      run_op(TM[v], TX[v], TY[v], TZ[v], 1'b0);
      verify(TM[v], TX[v], TY[v], TZ[v]);
    end

    // R8 outputs hold after done
    hx = x_out; hy = y_out; hz = z_out;
    repeat (5) @(negedge clk);
    check(x_out == hx && y_out == hy && z_out == hz, "R8", "hold after done", x_out, hx);

    // R9 start while busy is ignored
    run_op(TM[0], TX[0], TY[0], TZ[0], 1'b1);
    verify(TM[0], TX[0], TY[0], TZ[0]);
    repeat (3) @(negedge clk);
    check(!dir_valid && !done, "R9", "no second operation", {dir_valid, done}, 0);

    // R10 reserved mode code
    hx = x_out; hy = y_out; hz = z_out;
    @(negedge clk);
    mode = 2'b11; x_in = W'(100); y_in = W'(200); z_in = W'(300); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawAny = 0;
    for (int t = 0; t < 20; t++) begin
      if (dir_valid || done) sawAny = 1;
      @(negedge clk);
    end
    check(!sawAny, "R10", "no activity", sawAny, 0);
    check(x_out == hx && y_out == hy && z_out == hz, "R10", "outputs unchanged", z_out, hz);

    // R11 small negative operands, arithmetic shifts
    run_op(2'b00, 3, -2, 0, 1'b0);
    check(nDir == N, "R11", "strobes small vec", nDir, N);
    follow_check(2'b00, 3, -2, "R11");
    run_op(2'b01, -5, -3, 100, 1'b0);
    follow_check(2'b01, -5, -3, "R11");
    run_op(2'b10, 20, -7, 0, 1'b0);
    follow_check(2'b10, 20, -7, "R11");

    finish_up();
  end

endmodule